// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single 8-bit output compare channel that sits beside a timer counter. It compares the counter value with an active compare value on every cycle. When they are equal during a timer tick, it raises a match pulse that the counter can use to clear itself. The match is turned into a sticky compare flag with an interrupt request, and it drives a registered waveform output bit.

Software writes the compare value through a CPU strobe. In PWM modes the write lands in a shadow buffer. That buffer moves into the active register only when the counter reaches the end of its range that the mode selects, top or bottom. In the other modes the write takes effect at once.

A write to the counter blocks the match of the following tick. A force strobe moves the output bit as a match would, but it leaves the flag and the match pulse alone.

Top module: `tmr_cmp_channel`

## Requirements
- R1: `match_pulse` is high in a cycle only when `tick_en` is high, `cnt_val` equals the active compare value, and the match is not blocked (see R6). It is combinational, so it is visible in that same cycle.
- R2: A match in tick k sets `cmp_flag` at the clock edge that closes the next cycle with `tick_en` high. The flag never sets in a cycle with `tick_en` low.
- R3: `cmp_flag` clears on `irq_ack`. It also clears on `flag_wr` with `flag_wdata`=1, while `flag_wr` with `flag_wdata`=0 leaves it unchanged. A set in the same cycle wins over a clear. `irq` equals `cmp_flag` AND `irq_en`.
- R4: With `pwm_mode`=1, `wr_cmp` loads only the shadow buffer. The buffer is copied to the active value on a tick where the selected end indication is high: `cnt_top` when `upd_at_top`=1, `cnt_bot` when `upd_at_top`=0.
- R5: With `pwm_mode`=0, `wr_cmp` loads the active compare value at the edge of the write, whether or not a tick is present.
- R6: A `cnt_wr` strobe blocks any match in the next cycle with `tick_en` high, even if ticks are stopped between the two. A blocked match sets no flag and leaves `oc_bit` unchanged.
- R7: With `pwm_mode`=0, a match updates `oc_bit` at the edge that closes the match tick, according to `out_mode`: 2'b00 holds, 2'b01 toggles, 2'b10 clears, 2'b11 sets. `oc_drive` is 0 exactly when `out_mode`=2'b00. `out_mode` is unbuffered.
- R8: With `pwm_mode`=0, `force_stb` updates `oc_bit` at its own edge by the same `out_mode` rule, with or without a tick. It never asserts `match_pulse` and never sets `cmp_flag`.
- R9: With `pwm_mode`=1, `force_stb` and matches leave `oc_bit` unchanged.
- R10: Reset clears `oc_bit`, `cmp_flag`, the active value and the buffer. `oc_bit` keeps its value across changes of `pwm_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable |
| cnt_val | input | 8 | Current counter value |
| cnt_top | input | 1 | Counter is at top |
| cnt_bot | input | 1 | Counter is at bottom |
| pwm_mode | input | 1 | 1 selects a PWM mode |
| upd_at_top | input | 1 | PWM buffer copy point: 1 at top, 0 at bottom |
| out_mode | input | 2 | Output action on match or force |
| wr_cmp | input | 1 | CPU write strobe for the compare value |
| wr_data | input | 8 | Compare value write data |
| force_stb | input | 1 | Force strobe |
| cnt_wr | input | 1 | Notification of a CPU write to the counter |
| flag_wr | input | 1 | CPU write strobe for the flag |
| flag_wdata | input | 1 | Flag write data, 1 clears |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_en | input | 1 | Interrupt enable |
| match_pulse | output | 1 | Unblocked match in this tick |
| cmp_flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |
| oc_bit | output | 1 | Registered waveform output bit |
| oc_drive | output | 1 | Output connected (mode not 2'b00) |

## Verification
`match_pulse` is due in the same cycle as the tick that carries equality. The bench therefore samples it one time unit after driving the inputs on the falling edge. `oc_bit` is due after one rising edge, whether it follows a match tick or a force strobe. `cmp_flag` is due only after the edge of the next tick, so the bench checks that it is still clear after the first edge and after untimed cycles, and set only after the second tick. Buffer copies and blocked matches are observed through `match_pulse` on the tick that follows the copy point or the counter write.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } out_mode_e;

  // Next output bit value for a match or force under the given action.
  function automatic logic oc_next(input logic [1:0] mode, input logic cur);
    case (out_mode_e'(mode))
      OM_TOGGLE: oc_next = ~cur;
      OM_CLEAR:  oc_next = 1'b0;
      OM_SET:    oc_next = 1'b1;
      default:   oc_next = cur;
    endcase
  endfunction

  // Buffer copy point chosen by the update selector.
  function automatic logic copy_point(input logic sel_top, input logic at_top,
                                      input logic at_bot);
    copy_point = sel_top ? at_top : at_bot;
  endfunction

endpackage

// File: rtl/cmp_value_reg.sv
module cmp_value_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         pwm_mode,
  input  logic         upd_at_top,
  input  logic         cnt_top,
  input  logic         cnt_bot,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] active
);
  import tmr_cmp_pkg::*;

  logic [W-1:0] shadow;
  logic         copy_now;

  assign copy_now = pwm_mode && tick_en && copy_point(upd_at_top, cnt_top, cnt_bot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (wr_cmp) begin
      shadow <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (!pwm_mode && wr_cmp) begin
      active <= wr_data;
    end else if (copy_now) begin
      active <= shadow;
    end
  end

endmodule

// File: rtl/cmp_match_ctl.sv
module cmp_match_ctl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] active,
  input  logic         cnt_wr,
  input  logic         flag_wr,
  input  logic         flag_wdata,
  input  logic         irq_ack,
  output logic         match_pulse,
  output logic         match_pend,
  output logic         blk_pend,
  output logic         cmp_flag
);

  logic equal;
  logic flag_set;
  logic flag_clr;

  assign equal       = (cnt_val == active);
  assign match_pulse = tick_en && equal && !blk_pend;
  assign flag_set    = tick_en && match_pend;
  assign flag_clr    = irq_ack || (flag_wr && flag_wdata);

  // Block window: opened by a counter write, closed by the next tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_pend <= 1'b0;
    end else if (cnt_wr) begin
      blk_pend <= 1'b1;
    end else if (tick_en) begin
      blk_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pend <= 1'b0;
    end else if (tick_en) begin
      match_pend <= match_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_flag <= 1'b0;
    end else if (flag_set) begin
      cmp_flag <= 1'b1;
    end else if (flag_clr) begin
      cmp_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/cmp_wave.sv
module cmp_wave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_mode,
  input  logic [1:0] out_mode,
  input  logic       match_pulse,
  input  logic       force_stb,
  output logic       oc_bit,
  output logic       oc_drive
);
  import tmr_cmp_pkg::*;

  logic apply;

  assign apply    = !pwm_mode && (match_pulse || force_stb);
  assign oc_drive = (out_mode != OM_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_bit <= 1'b0;
    end else if (apply) begin
      oc_bit <= oc_next(out_mode, oc_bit);
    end
  end

endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_top,
  input  logic         cnt_bot,
  input  logic         pwm_mode,
  input  logic         upd_at_top,
  input  logic [1:0]   out_mode,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_data,
  input  logic         force_stb,
  input  logic         cnt_wr,
  input  logic         flag_wr,
  input  logic         flag_wdata,
  input  logic         irq_ack,
  input  logic         irq_en,
  output logic         match_pulse,
  output logic         cmp_flag,
  output logic         irq,
  output logic         oc_bit,
  output logic         oc_drive
);

  logic [W-1:0] active;
  logic         match_pend;
  logic         blk_pend;

  cmp_value_reg #(.W(W)) i_value (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .pwm_mode   (pwm_mode),
    .upd_at_top (upd_at_top),
    .cnt_top    (cnt_top),
    .cnt_bot    (cnt_bot),
    .wr_cmp     (wr_cmp),
    .wr_data    (wr_data),
    .active     (active)
  );

  cmp_match_ctl #(.W(W)) i_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cnt_val     (cnt_val),
    .active      (active),
    .cnt_wr      (cnt_wr),
    .flag_wr     (flag_wr),
    .flag_wdata  (flag_wdata),
    .irq_ack     (irq_ack),
    .match_pulse (match_pulse),
    .match_pend  (match_pend),
    .blk_pend    (blk_pend),
    .cmp_flag    (cmp_flag)
  );

  cmp_wave i_wave (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_mode    (pwm_mode),
    .out_mode    (out_mode),
    .match_pulse (match_pulse),
    .force_stb   (force_stb),
    .oc_bit      (oc_bit),
    .oc_drive    (oc_drive)
  );

  assign irq = cmp_flag && irq_en;

endmodule

// File: rtl/tmr_cmp_channel_chk.sv
module tmr_cmp_channel_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         cnt_top,
  input logic         cnt_bot,
  input logic         pwm_mode,
  input logic         upd_at_top,
  input logic [1:0]   out_mode,
  input logic         wr_cmp,
  input logic [W-1:0] wr_data,
  input logic         force_stb,
  input logic         cnt_wr,
  input logic         flag_wr,
  input logic         flag_wdata,
  input logic         irq_ack,
  input logic         match_pulse,
  input logic         cmp_flag,
  input logic         oc_bit,
  input logic [W-1:0] active,
  input logic         match_pend
);

  logic upd_hit;
  assign upd_hit = upd_at_top ? cnt_top : cnt_bot;

  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cmp_flag) |=> !cmp_flag); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(tick_en && match_pend)) |=> !cmp_flag); // R3

  AST_WRITE_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_flag && flag_wr && !flag_wdata && !irq_ack) |=> cmp_flag); // R3

  AST_PWM_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !(tick_en && upd_hit)) |=> $stable(active)); // R4

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp && !pwm_mode) |=> (active == $past(wr_data))); // R5

  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_wr) && $past(rst_n) && tick_en) |-> !match_pulse); // R6

  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |=> $stable(oc_bit)); // R7

  AST_FORCE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !tick_en) |-> !match_pulse); // R8

  AST_PWM_OC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode |=> $stable(oc_bit)); // R9

endmodule

bind tmr_cmp_channel tmr_cmp_channel_chk #(.W(W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .cnt_top     (cnt_top),
  .cnt_bot     (cnt_bot),
  .pwm_mode    (pwm_mode),
  .upd_at_top  (upd_at_top),
  .out_mode    (out_mode),
  .wr_cmp      (wr_cmp),
  .wr_data     (wr_data),
  .force_stb   (force_stb),
  .cnt_wr      (cnt_wr),
  .flag_wr     (flag_wr),
  .flag_wdata  (flag_wdata),
  .irq_ack     (irq_ack),
  .match_pulse (match_pulse),
  .cmp_flag    (cmp_flag),
  .oc_bit      (oc_bit),
  .active      (active),
  .match_pend  (match_pend)
);

// File: tb/test_tmr_cmp_channel.sv
module test_tmr_cmp_channel;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, cnt_top, cnt_bot, pwm_mode, upd_at_top;
  logic [7:0] cnt_val, wr_data;
  logic [1:0] out_mode;
  logic       wr_cmp, force_stb, cnt_wr, flag_wr, flag_wdata, irq_ack, irq_en;
  logic       match_pulse, cmp_flag, irq, oc_bit, oc_drive;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #5 clk = ~clk;

  tmr_cmp_channel i_tmr_cmp_channel (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cmp(input logic [7:0] v);
    wr_cmp = 1'b1; wr_data = v; cyc(); wr_cmp = 1'b0;
  endtask

  task automatic clear_flag();
    flag_wr = 1'b1; flag_wdata = 1'b1; cyc(); flag_wr = 1'b0;
  endtask

  // Flush any pending match with two non-matching ticks, then clear the flag.
  task automatic settle();
    cnt_val = 8'hF0; tick_en = 1'b1; cyc(2); tick_en = 1'b0; clear_flag();
  endtask

  task automatic t_reset();
    #1;
    chk("R10 oc_bit after reset", oc_bit, 1'b0);
    chk("R10 flag after reset", cmp_flag, 1'b0);
    chk("R3 irq after reset", irq, 1'b0);
    chk("R7 drive off in hold mode", oc_drive, 1'b0);
  endtask

  task automatic t_match_flag();
    pwm_mode = 1'b0; out_mode = 2'b01; irq_en = 1'b1;
    load_cmp(8'd5); settle();
    cnt_val = 8'd4; tick_en = 1'b1; #1;
    chk("R1 no match on unequal", match_pulse, 1'b0);
    cnt_val = 8'd5; #1;
    chk("R1 match on equal", match_pulse, 1'b1);
    cyc();
    chk("R7 toggle after match", oc_bit, 1'b1);
    chk("R2 flag not yet set", cmp_flag, 1'b0);
    cnt_val = 8'hF0; cyc();
    chk("R2 flag set on following tick", cmp_flag, 1'b1);
    chk("R3 irq follows flag", irq, 1'b1);
    irq_en = 1'b0; #1;
    chk("R3 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    tick_en = 1'b0;
    flag_wr = 1'b1; flag_wdata = 1'b0; cyc(); flag_wr = 1'b0;
    chk("R3 write zero keeps flag", cmp_flag, 1'b1);
    clear_flag();
    chk("R3 write one clears flag", cmp_flag, 1'b0);
    // Flag waits for a tick after the match tick.
    cnt_val = 8'd5; tick_en = 1'b1; cyc();
    cnt_val = 8'hF0; tick_en = 1'b0; cyc(3);
    chk("R2 no set without tick", cmp_flag, 1'b0);
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
    chk("R2 set on delayed tick", cmp_flag, 1'b1);
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
    chk("R3 ack clears flag", cmp_flag, 1'b0);
  endtask

  task automatic hit5();
    cnt_val = 8'd5; tick_en = 1'b1; cyc(); tick_en = 1'b0; cnt_val = 8'hF0;
  endtask

  task automatic t_modes();
    settle();
    out_mode = 2'b11; hit5();
    chk("R7 set mode", oc_bit, 1'b1);
    out_mode = 2'b10; hit5();
    chk("R7 clear mode", oc_bit, 1'b0);
    out_mode = 2'b00; #1;
    chk("R7 drive off", oc_drive, 1'b0);
    hit5();
    chk("R7 hold mode", oc_bit, 1'b0);
    out_mode = 2'b01; #1;
    chk("R7 drive on", oc_drive, 1'b1);
    hit5();
    chk("R7 toggle mode", oc_bit, 1'b1);
  endtask

  task automatic t_force();
    settle();
    out_mode = 2'b10; force_stb = 1'b1; #1;
    chk("R8 force gives no match pulse", match_pulse, 1'b0);
    cyc(); force_stb = 1'b0;
    chk("R8 force clears", oc_bit, 1'b0);
    out_mode = 2'b01; force_stb = 1'b1; cyc(); force_stb = 1'b0;
    chk("R8 force toggles", oc_bit, 1'b1);
    tick_en = 1'b1; cyc(2); tick_en = 1'b0;
    chk("R8 force sets no flag", cmp_flag, 1'b0);
  endtask

  task automatic t_pwm();
    pwm_mode = 1'b1; upd_at_top = 1'b1;
    load_cmp(8'd9);
    cnt_val = 8'd5; tick_en = 1'b1; #1;
    chk("R4 old value still active", match_pulse, 1'b1);
    cyc();
    chk("R9 match leaves oc in pwm", oc_bit, 1'b1);
    cnt_val = 8'd9; #1;
    chk("R4 buffered value not active", match_pulse, 1'b0);
    cnt_val = 8'd0; cnt_top = 1'b1; cyc(); cnt_top = 1'b0;
    cnt_val = 8'd9; #1;
    chk("R4 copied at top", match_pulse, 1'b1);
    cyc(); tick_en = 1'b0;
    upd_at_top = 1'b0; load_cmp(8'd20);
    tick_en = 1'b1; cnt_val = 8'd0; cnt_top = 1'b1; cyc(); cnt_top = 1'b0;
    cnt_val = 8'd20; #1;
    chk("R4 no copy at top when bottom chosen", match_pulse, 1'b0);
    cnt_val = 8'd0; cnt_bot = 1'b1; cyc(); cnt_bot = 1'b0;
    cnt_val = 8'd20; #1;
    chk("R4 copied at bottom", match_pulse, 1'b1);
    cyc(); tick_en = 1'b0;
    force_stb = 1'b1; cyc(); force_stb = 1'b0;
    chk("R9 force ignored in pwm", oc_bit, 1'b1);
    pwm_mode = 1'b0; cyc();
    chk("R10 oc kept across mode change", oc_bit, 1'b1);
    settle();
  endtask

  task automatic t_block();
    load_cmp(8'd7);
    cnt_val = 8'd7; tick_en = 1'b1; #1;
    chk("R5 direct load active", match_pulse, 1'b1);
    cyc(); tick_en = 1'b0;
    load_cmp(8'd5); settle();
    cnt_val = 8'd5; cnt_wr = 1'b1; cyc(); cnt_wr = 1'b0;
    cyc(2);
    tick_en = 1'b1; #1;
    chk("R6 match blocked after counter write", match_pulse, 1'b0);
    cyc();
    chk("R6 blocked match keeps oc", oc_bit, 1'b0);
    cnt_val = 8'hF0; cyc();
    chk("R6 blocked match sets no flag", cmp_flag, 1'b0);
    cnt_val = 8'd5; #1;
    chk("R6 block lasts one tick", match_pulse, 1'b1);
    cyc(); tick_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; cnt_val = 8'hF0; cnt_top = 1'b0; cnt_bot = 1'b0;
    pwm_mode = 1'b0; upd_at_top = 1'b1; out_mode = 2'b00; wr_cmp = 1'b0;
    wr_data = 8'd0; force_stb = 1'b0; cnt_wr = 1'b0; flag_wr = 1'b0;
    flag_wdata = 1'b0; irq_ack = 1'b0; irq_en = 1'b0;
    cyc(3); rst_n = 1'b1;
    t_reset();
    t_match_flag();
    t_modes();
    t_force();
    t_pwm();
    t_block();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule